// File: doc/BRIEF.md
# Dual-Bank Register File for an 8-bit Processor

This block is the programmer-visible register storage of an 8-bit processor core. It keeps six general byte registers (B, C, D, E, H, L) in two banks, main and alternate, plus an accumulator and a flag register that have their own pair of banks. Each bank set is switched by its own swap strobe, so exchanging the whole active set takes one clock cycle and moves no data. Next to the banked storage it holds a 16-bit stack pointer, two 16-bit index registers (IX, IY), an interrupt-vector-base byte (I) and a refresh counter byte (R). None of these is banked.

The surrounding core reaches the storage through two independent combinational read ports and one synchronous write port. Each port selects either a single byte or a 16-bit register pair. A fetch pulse advances the refresh counter. A transfer command copies I or R into the accumulator and loads the parity/overflow flag from the interrupt-enable-2 input. Decoding, arithmetic and bus sequencing live outside this block.

Top module: `dual_bank_regfile`

## Requirements
- R1: With wide=0 the select code reads or writes one byte: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=F, 7=A, 8=I, 9=R. Codes 10 to 15 read as zero, and a write to them has no effect. A byte read returns the value in bits 7:0, with bits 15:8 zero.
- R2: The two read ports are independent. Each returns the selected register in the same cycle, with no clock delay.
- R3: With wide=1 the select code names a pair: 0=BC, 1=DE, 2=HL, 3=AF, 4=SP, 5=IX, 6=IY. Codes 7 to 15 read as zero. In a pair, bits 15:8 belong to the first-named register (B, D, H, A) and bits 7:0 to the second.
- R4: A pulse on swap_gen toggles which bank of B..L is active. The inactive bank keeps its contents. A, F, SP, IX, IY, I and R are unaffected.
- R5: A pulse on swap_af toggles which bank of A and F is active. The inactive bank keeps its contents, and the general registers are unaffected.
- R6: SP, IX and IY are written and read only as pairs and are not affected by either swap strobe.
- R7: Each cycle with fetch=1 adds one to R bits 6:0, wrapping from 0x7F to 0x00, and leaves bit 7 unchanged. A write to R in the same cycle takes priority over the increment.
- R8: xfer_op=1 copies I into A, and xfer_op=2 copies R into A. In both cases F bit 2 (parity/overflow) takes the value of iff2, and the other F bits are kept. The transfer takes priority over a port write to A, F or AF in the same cycle.
- R9: A read of a register that is being written in the same cycle returns the old value. The new value is visible from the cycle after the write.
- R10: A synchronous reset clears every register and selects the main bank for both bank sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_sel | input | 4 | Read port A select code |
| rd_a_wide | input | 1 | Read port A: 1 = pair, 0 = byte |
| rd_a_data | output | 16 | Read port A data |
| rd_b_sel | input | 4 | Read port B select code |
| rd_b_wide | input | 1 | Read port B: 1 = pair, 0 = byte |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_wide | input | 1 | Write: 1 = pair, 0 = byte (bits 7:0 used) |
| wr_sel | input | 4 | Write select code |
| wr_data | input | 16 | Write data |
| swap_gen | input | 1 | Toggle the active general-register bank |
| swap_af | input | 1 | Toggle the active accumulator/flag bank |
| fetch | input | 1 | Opcode fetch pulse, advances R |
| xfer_op | input | 2 | 0 = none, 1 = A takes I, 2 = A takes R |
| iff2 | input | 1 | Interrupt-enable-2 state, copied to the flag |

## Verification
The properties assume that the inputs are settled before each rising edge. They also assume that a swap strobe lasts exactly one cycle per intended exchange, because a strobe held high keeps toggling the bank. The flag and pair checks are written only for cycles in which the matching swap strobe is low, since a swap in the same cycle sends the write to the bank that is leaving. The bench drives every input on the falling edge and pulses each swap for a single cycle. It never issues xfer_op=3, which has no defined meaning.

// File: rtl/rfile_pkg.sv
package rfile_pkg;
    localparam int BW      = 8;
    localparam int PW      = 2 * BW;
    localparam int SEL_W   = 4;
    localparam int NGEN    = 6;
    localparam int NBANK   = 2;
    localparam int NPAIR   = NGEN / 2;
    localparam int PV_BIT  = 2;
    localparam int RCNT_W  = BW - 1;

    localparam logic [SEL_W-1:0] SB_F = 4'd6;
    localparam logic [SEL_W-1:0] SB_A = 4'd7;
    localparam logic [SEL_W-1:0] SB_I = 4'd8;
    localparam logic [SEL_W-1:0] SB_R = 4'd9;

    localparam logic [SEL_W-1:0] SP_AF = 4'd3;
    localparam logic [SEL_W-1:0] SP_SP = 4'd4;
    localparam logic [SEL_W-1:0] SP_IX = 4'd5;
    localparam logic [SEL_W-1:0] SP_IY = 4'd6;

    typedef enum logic [1:0] {
        XF_NONE   = 2'd0,
        XF_A_OF_I = 2'd1,
        XF_A_OF_R = 2'd2
    } xfer_e;

    typedef logic [NGEN-1:0][BW-1:0] gen_set_t;

    typedef struct packed {
        logic [BW-1:0] acc;
        logic [BW-1:0] flg;
        logic [BW-1:0] ivec;
        logic [BW-1:0] rcnt;
        logic [PW-1:0] sp;
        logic [PW-1:0] ix;
        logic [PW-1:0] iy;
    } misc_view_t;

    function automatic logic [PW-1:0] read_mux(
        input logic [SEL_W-1:0] sel,
        input logic             wide,
        input gen_set_t         g,
        input misc_view_t       m
    );
        logic [PW-1:0] v;
        v = '0;
        if (wide) begin
            if (int'(sel) < NPAIR)
                v = {g[2*int'(sel)], g[2*int'(sel)+1]};
            else if (sel == SP_AF) v = {m.acc, m.flg};
            else if (sel == SP_SP) v = m.sp;
            else if (sel == SP_IX) v = m.ix;
            else if (sel == SP_IY) v = m.iy;
        end else begin
            if (int'(sel) < NGEN)  v = {{BW{1'b0}}, g[int'(sel)]};
            else if (sel == SB_F)  v = {{BW{1'b0}}, m.flg};
            else if (sel == SB_A)  v = {{BW{1'b0}}, m.acc};
            else if (sel == SB_I)  v = {{BW{1'b0}}, m.ivec};
            else if (sel == SB_R)  v = {{BW{1'b0}}, m.rcnt};
        end
        return v;
    endfunction
endpackage

// File: rtl/rf_gen_banks.sv
module rf_gen_banks
    import rfile_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             swap,
    input  logic             wr_en,
    input  logic             wr_wide,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [PW-1:0]    wr_data,
    output logic             bank_sel,
    output gen_set_t         cur
);
    gen_set_t bank_view [NBANK];

    always_ff @(posedge clk) begin
        if (rst)       bank_sel <= 1'b0;
        else if (swap) bank_sel <= ~bank_sel;
    end

    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
        gen_set_t regs_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q <= '0;
            end else if (wr_en && (int'(bank_sel) == gb)) begin
                for (int k = 0; k < NGEN; k++) begin
                    if (!wr_wide && int'(wr_sel) == k)
                        regs_q[k] <= wr_data[BW-1:0];
                    else if (wr_wide && int'(wr_sel) == k / 2)
                        regs_q[k] <= (k % 2 == 0) ? wr_data[PW-1:BW] : wr_data[BW-1:0];
                end
            end
        end
        assign bank_view[gb] = regs_q;
    end

    assign cur = bank_view[bank_sel];
endmodule

// File: rtl/rf_accf_banks.sv
module rf_accf_banks
    import rfile_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             swap,
    input  logic             wr_en,
    input  logic             wr_wide,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [PW-1:0]    wr_data,
    input  xfer_e            xfer,
    input  logic [BW-1:0]    xfer_val,
    input  logic             iff2,
    output logic             bank_sel,
    output logic [BW-1:0]    acc,
    output logic [BW-1:0]    flg
);
    logic [BW-1:0] acc_view [NBANK];
    logic [BW-1:0] flg_view [NBANK];
    logic          wr_a, wr_f, wr_af, do_xfer;

    assign wr_a    = wr_en && !wr_wide && wr_sel == SB_A;
    assign wr_f    = wr_en && !wr_wide && wr_sel == SB_F;
    assign wr_af   = wr_en &&  wr_wide && wr_sel == SP_AF;
    assign do_xfer = xfer == XF_A_OF_I || xfer == XF_A_OF_R;

    always_ff @(posedge clk) begin
        if (rst)       bank_sel <= 1'b0;
        else if (swap) bank_sel <= ~bank_sel;
    end

    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
        logic [BW-1:0] a_q, f_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                a_q <= '0;
                f_q <= '0;
            end else if (int'(bank_sel) == gb) begin
                if (do_xfer) begin
                    a_q         <= xfer_val;
                    f_q[PV_BIT] <= iff2;
                end else if (wr_af) begin
                    a_q <= wr_data[PW-1:BW];
                    f_q <= wr_data[BW-1:0];
                end else begin
                    if (wr_a) a_q <= wr_data[BW-1:0];
                    if (wr_f) f_q <= wr_data[BW-1:0];
                end
            end
        end
        assign acc_view[gb] = a_q;
        assign flg_view[gb] = f_q;
    end

    assign acc = acc_view[bank_sel];
    assign flg = flg_view[bank_sel];
endmodule

// File: rtl/rf_special.sv
module rf_special
    import rfile_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_wide,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [PW-1:0]    wr_data,
    input  logic             fetch,
    output logic [PW-1:0]    sp,
    output logic [PW-1:0]    ix,
    output logic [PW-1:0]    iy,
    output logic [BW-1:0]    ivec,
    output logic [BW-1:0]    rcnt
);
    logic wr_r;
    assign wr_r = wr_en && !wr_wide && wr_sel == SB_R;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0; ix <= '0; iy <= '0; ivec <= '0;
        end else if (wr_en) begin
            if (wr_wide && wr_sel == SP_SP) sp <= wr_data;
            if (wr_wide && wr_sel == SP_IX) ix <= wr_data;
            if (wr_wide && wr_sel == SP_IY) iy <= wr_data;
            if (!wr_wide && wr_sel == SB_I) ivec <= wr_data[BW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rcnt <= '0;
        else if (wr_r)  rcnt <= wr_data[BW-1:0];
        else if (fetch) rcnt[RCNT_W-1:0] <= rcnt[RCNT_W-1:0] + 1'b1;
    end
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
    import rfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  rd_a_sel,
    input  logic        rd_a_wide,
    output logic [15:0] rd_a_data,
    input  logic [3:0]  rd_b_sel,
    input  logic        rd_b_wide,
    output logic [15:0] rd_b_data,
    input  logic        wr_en,
    input  logic        wr_wide,
    input  logic [3:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic        swap_gen,
    input  logic        swap_af,
    input  logic        fetch,
    input  logic [1:0]  xfer_op,
    input  logic        iff2
);
    gen_set_t      gen_cur;
    logic          gen_bank, af_bank;
    logic [BW-1:0] a_cur, f_cur, i_val, r_val;
    logic [PW-1:0] sp_val, ix_val, iy_val;
    logic [BW-1:0] xfer_val;
    xfer_e         xfer;
    misc_view_t    misc;

    assign xfer     = xfer_e'(xfer_op);
    assign xfer_val = (xfer == XF_A_OF_R) ? r_val : i_val;

    rf_gen_banks u_gen (
        .clk(clk), .rst(rst), .swap(swap_gen),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
        .bank_sel(gen_bank), .cur(gen_cur)
    );

    rf_accf_banks u_accf (
        .clk(clk), .rst(rst), .swap(swap_af),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
        .xfer(xfer), .xfer_val(xfer_val), .iff2(iff2),
        .bank_sel(af_bank), .acc(a_cur), .flg(f_cur)
    );

    rf_special u_spec (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
        .fetch(fetch),
        .sp(sp_val), .ix(ix_val), .iy(iy_val), .ivec(i_val), .rcnt(r_val)
    );

    assign misc = '{acc: a_cur, flg: f_cur, ivec: i_val, rcnt: r_val,
                    sp: sp_val, ix: ix_val, iy: iy_val};

    assign rd_a_data = read_mux(rd_a_sel, rd_a_wide, gen_cur, misc);
    assign rd_b_data = read_mux(rd_b_sel, rd_b_wide, gen_cur, misc);
endmodule

// File: rtl/rf_checker.sv
module rf_checker
    import rfile_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          wr_wide,
    input logic [3:0]    wr_sel,
    input logic [15:0]   wr_data,
    input logic          swap_gen,
    input logic          swap_af,
    input logic          fetch,
    input logic [1:0]    xfer_op,
    input logic          iff2,
    input logic [3:0]    rd_a_sel,
    input logic          rd_a_wide,
    input logic [15:0]   rd_a_data,
    input logic          gen_bank,
    input logic          af_bank,
    input gen_set_t      gen_cur,
    input logic [BW-1:0] f_cur,
    input logic [BW-1:0] r_val
);
    logic wr_r, wr_flags;
    assign wr_r     = wr_en && !wr_wide && wr_sel == SB_R;
    assign wr_flags = wr_en && ((!wr_wide && wr_sel == SB_F) || (wr_wide && wr_sel == SP_AF));

    // R10
    reset_main_bank_chk: assert property (@(posedge clk)
        rst |=> (gen_bank == 1'b0 && af_bank == 1'b0));

    // R7
    refresh_count_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch && !wr_r) |=> (r_val[BW-1] == $past(r_val[BW-1]) &&
                              r_val[RCNT_W-1:0] == $past(r_val[RCNT_W-1:0]) + 1'b1));

    // R7
    refresh_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fetch && !wr_r) |=> $stable(r_val));

    // R8
    pv_from_iff2_chk: assert property (@(posedge clk) disable iff (rst)
        ((xfer_op == 2'd1 || xfer_op == 2'd2) && !swap_af) |=> f_cur[PV_BIT] == $past(iff2));

    // R3
    pair_order_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_wide && wr_sel == 4'd0 && !swap_gen) |=>
            (gen_cur[0] == $past(wr_data[15:8]) && gen_cur[1] == $past(wr_data[7:0])));

    // R4
    gen_swap_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (swap_gen && !swap_af && xfer_op == 2'd0 && !wr_flags) |=> $stable(f_cur));

    // R9
    read_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && xfer_op == 2'd0 && !swap_gen && !swap_af && !fetch) |=>
            (rd_a_sel != $past(rd_a_sel) || rd_a_wide != $past(rd_a_wide) ||
             rd_a_data == $past(rd_a_data)));
endmodule

bind dual_bank_regfile rf_checker u_rf_checker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel),
    .wr_data(wr_data), .swap_gen(swap_gen), .swap_af(swap_af), .fetch(fetch),
    .xfer_op(xfer_op), .iff2(iff2), .rd_a_sel(rd_a_sel), .rd_a_wide(rd_a_wide),
    .rd_a_data(rd_a_data), .gen_bank(gen_bank), .af_bank(af_bank),
    .gen_cur(gen_cur), .f_cur(f_cur), .r_val(r_val)
);

// File: tb/dual_bank_regfile_bench.sv
module dual_bank_regfile_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  rd_a_sel, rd_b_sel, wr_sel;
    logic        rd_a_wide, rd_b_wide, wr_en, wr_wide;
    logic [15:0] rd_a_data, rd_b_data, wr_data;
    logic        swap_gen, swap_af, fetch, iff2;
    logic [1:0]  xfer_op;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bank_regfile u_dual_bank_regfile (
        .clk(clk), .rst(rst),
        .rd_a_sel(rd_a_sel), .rd_a_wide(rd_a_wide), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_wide(rd_b_wide), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
        .swap_gen(swap_gen), .swap_af(swap_af), .fetch(fetch),
        .xfer_op(xfer_op), .iff2(iff2)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_a(input string tag, input logic [3:0] s, input logic w, input logic [15:0] exp);
        rd_a_sel = s; rd_a_wide = w; #1;
        check(tag, rd_a_data, exp);
    endtask

    task automatic chk_b(input string tag, input logic [3:0] s, input logic w, input logic [15:0] exp);
        rd_b_sel = s; rd_b_wide = w; #1;
        check(tag, rd_b_data, exp);
    endtask

    task automatic wr(input logic [3:0] s, input logic w, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_wide = w; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse_gen();
        swap_gen = 1'b1; step(); swap_gen = 1'b0;
    endtask

    task automatic pulse_af();
        swap_af = 1'b1; step(); swap_af = 1'b0;
    endtask

    task automatic t_reset();
        for (int k = 0; k < 10; k++) chk_a("R10 byte after reset", 4'(k), 1'b0, 16'h0000);
        chk_a("R10 SP after reset", 4'd4, 1'b1, 16'h0000);
    endtask

    task automatic t_bytes();
        for (int k = 0; k < 10; k++) wr(4'(k), 1'b0, 16'hAB00 | 16'(8'h10 + k));
        for (int k = 0; k < 10; k++) chk_a("R1 byte readback", 4'(k), 1'b0, 16'(8'h10 + k));
        wr(4'd12, 1'b0, 16'h00EE);
        for (int k = 10; k < 16; k++) chk_a("R1 unused byte code", 4'(k), 1'b0, 16'h0000);
        chk_a("R1 B after unused write", 4'd0, 1'b0, 16'h0010);
        chk_b("R2 port B pair DE", 4'd1, 1'b1, 16'h1213);
        chk_a("R2 port A pair AF", 4'd3, 1'b1, 16'h1716);
        chk_b("R2 port B byte L", 4'd5, 1'b0, 16'h0015);
    endtask

    task automatic t_pairs();
        wr(4'd2, 1'b1, 16'h1234);
        chk_a("R3 H from pair", 4'd4, 1'b0, 16'h0012);
        chk_b("R3 L from pair", 4'd5, 1'b0, 16'h0034);
        wr(4'd3, 1'b1, 16'hC3A5);
        chk_a("R3 A from AF", 4'd7, 1'b0, 16'h00C3);
        chk_b("R3 F from AF", 4'd6, 1'b0, 16'h00A5);
        chk_a("R3 unused pair code", 4'd9, 1'b1, 16'h0000);
    endtask

    task automatic t_genswap();
        wr(4'd0, 1'b1, 16'h1111);
        pulse_gen();
        chk_a("R4 alternate BC clear", 4'd0, 1'b1, 16'h0000);
        chk_b("R4 A kept over gen swap", 4'd7, 1'b0, 16'h00C3);
        wr(4'd0, 1'b1, 16'h2222);
        pulse_gen();
        chk_a("R4 main BC restored", 4'd0, 1'b1, 16'h1111);
        chk_b("R4 main HL restored", 4'd2, 1'b1, 16'h1234);
        pulse_gen();
        chk_a("R4 alternate BC kept", 4'd0, 1'b1, 16'h2222);
        pulse_gen();
    endtask

    task automatic t_afswap();
        pulse_af();
        chk_a("R5 alternate AF clear", 4'd3, 1'b1, 16'h0000);
        chk_b("R5 BC kept over af swap", 4'd0, 1'b1, 16'h1111);
        wr(4'd3, 1'b1, 16'hAABB);
        pulse_af();
        chk_a("R5 main AF restored", 4'd3, 1'b1, 16'hC3A5);
        pulse_af();
        chk_a("R5 alternate AF kept", 4'd3, 1'b1, 16'hAABB);
        pulse_af();
    endtask

    task automatic t_special();
        wr(4'd4, 1'b1, 16'hFFFE);
        wr(4'd5, 1'b1, 16'h4000);
        wr(4'd6, 1'b1, 16'h5001);
        pulse_gen();
        pulse_af();
        chk_a("R6 SP after swaps", 4'd4, 1'b1, 16'hFFFE);
        chk_a("R6 IX after swaps", 4'd5, 1'b1, 16'h4000);
        chk_b("R6 IY after swaps", 4'd6, 1'b1, 16'h5001);
        pulse_gen();
        pulse_af();
    endtask

    task automatic t_refresh();
        wr(4'd9, 1'b0, 16'h00FE);
        fetch = 1'b1; step(); step(); step(); fetch = 1'b0;
        chk_a("R7 bit7 kept low7 wraps", 4'd9, 1'b0, 16'h0081);
        wr(4'd9, 1'b0, 16'h007F);
        fetch = 1'b1; step(); fetch = 1'b0;
        chk_a("R7 0x7F wraps to 0x00", 4'd9, 1'b0, 16'h0000);
        fetch = 1'b1; wr(4'd9, 1'b0, 16'h0055); fetch = 1'b0;
        chk_a("R7 write beats fetch", 4'd9, 1'b0, 16'h0055);
        step();
        chk_a("R7 no fetch holds", 4'd9, 1'b0, 16'h0055);
    endtask

    task automatic t_xfer();
        wr(4'd8, 1'b0, 16'h003C);
        wr(4'd6, 1'b0, 16'h0000);
        iff2 = 1'b1; xfer_op = 2'd1; step(); xfer_op = 2'd0;
        chk_a("R8 A takes I", 4'd7, 1'b0, 16'h003C);
        chk_b("R8 PV set from iff2", 4'd6, 1'b0, 16'h0004);
        wr(4'd6, 1'b0, 16'h00FF);
        iff2 = 1'b0; xfer_op = 2'd2;
        wr(4'd3, 1'b1, 16'h9999);
        xfer_op = 2'd0;
        chk_a("R8 A takes R over write", 4'd7, 1'b0, 16'h0055);
        chk_b("R8 PV cleared from iff2", 4'd6, 1'b0, 16'h00FB);
    endtask

    task automatic t_same_cycle();
        wr(4'd1, 1'b0, 16'h0042);
        wr_en = 1'b1; wr_sel = 4'd1; wr_wide = 1'b0; wr_data = 16'h0099;
        chk_a("R9 old value during write", 4'd1, 1'b0, 16'h0042);
        chk_b("R9 old pair during write", 4'd0, 1'b1, 16'h1142);
        step();
        wr_en = 1'b0;
        chk_a("R9 new value next cycle", 4'd1, 1'b0, 16'h0099);
    endtask

    initial begin
        rst = 1'b1; wr_en = 0; wr_wide = 0; wr_sel = 0; wr_data = 0;
        rd_a_sel = 0; rd_a_wide = 0; rd_b_sel = 0; rd_b_wide = 0;
        swap_gen = 0; swap_af = 0; fetch = 0; xfer_op = 0; iff2 = 0;
        @(negedge clk); step(); step();
        rst = 1'b0;
        step();
        t_reset();
        t_bytes();
        t_pairs();
        t_genswap();
        t_afswap();
        t_special();
        t_refresh();
        t_xfer();
        t_same_cycle();
        rst = 1'b1; step(); rst = 1'b0;
        chk_a("R10 reset clears BC", 4'd0, 1'b1, 16'h0000);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule